// File: doc/BRIEF.md
# IDE Access Strobe Timer

This block times a single IDE register access. When it is idle and sees a request, it drives the active-low chip select for a programmed number of clock cycles. It also asserts the active-low read or write strobe, according to the access direction, after a programmed delay counted from the start of select. Select and the strobe release together. One cycle later a single-cycle done pulse marks the end of the access. The block runs on a clock of about 14.18 MHz, so one cycle is roughly 70.5 ns.

Both the select length and the strobe delay come from an eight-entry irregular table, indexed by a 3-bit speed code. The speed code is held in a configuration register written through a byte-wide port. A separate slow-access input, driven from an address bit by the surrounding decoder, bypasses the table and forces a fixed conservative timing. The speed code is sampled when an access starts, so writing a new code during an access only affects later accesses.

Top module: `ideStrobeTimer`

## Requirements
- R1: After reset selN, iorN and iowN are high, done is low, and the speed code is 0 (an access then uses 7 select cycles with a strobe delay of 2).
- R2: A configuration write stores bits [7:5] of the byte as the speed code. Bits [4:0] have no effect on timing.
- R3: Speed codes 0, 1 and 2 give select lengths of 7, 9 and 11 cycles, with strobe delays of 2, 3 and 4 cycles.
- R4: Speed codes 3, 4, 5, 6 and 7 give select lengths of 5, 5, 5, 15 and 5 cycles, with strobe delays of 1, 2, 3, 4 and 1 cycles.
- R5: Select goes low in the cycle after the clock edge that accepts a request and stays low for exactly the select length. The strobe goes low exactly "delay" cycles after select goes low. Select and the strobe return high on the same edge.
- R6: A read (reqWrite=0) pulses only iorN and a write (reqWrite=1) pulses only iowN. The two strobes are never low together.
- R7: With reqSlow=1 the access uses 11 select cycles and a strobe delay of 4, whatever the speed code.
- R8: done is high for exactly one cycle, in the cycle right after select returns high.
- R9: A request is accepted only while idle. Requests raised during an access or its done cycle are dropped and do not start a later access.
- R10: The speed code is sampled when a request is accepted. A configuration write during an access leaves that access unchanged and applies from the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Access clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Access request, sampled while idle |
| reqWrite | input | 1 | 1 = write access, 0 = read access |
| reqSlow | input | 1 | Forces the fixed slow timing |
| cfgWrite | input | 1 | Speed register write enable |
| cfgData | input | 8 | Speed register write byte; code in bits [7:5] |
| selN | output | 1 | Active-low chip select |
| iorN | output | 1 | Active-low read strobe |
| iowN | output | 1 | Active-low write strobe |
| done | output | 1 | One-cycle end-of-access pulse |

## Verification
The bench programs every speed code and measures, for each access, the number of select cycles, the strobe offset, the shared release edge and the done position. A wrong table entry or an off-by-one counter shows up there as a select one cycle too long or too short. The bench also writes bytes whose low bits are scrambled, to catch a design that takes the code from the wrong field. Slow mode is combined with a fast code so that an override that is not applied gives 5 cycles instead of 11. It also rewrites the speed register and raises a request in mid-access. A design that does not latch the code would then stretch or cut the running access, and one that queues requests would start a second access without being asked.

// File: rtl/ideTimPkg.sv
package ideTimPkg;
  localparam int CNT_W   = 4;
  localparam int SPEED_W = 3;
  localparam logic [CNT_W-1:0] SLOW_SEL = 4'd11;
  localparam logic [CNT_W-1:0] SLOW_DLY = 4'd4;

  typedef struct packed {
    logic startAcc;
    logic countEn;
  } ctlStrobes_t;

  typedef struct packed {
    logic [CNT_W-1:0] selLen;
    logic [CNT_W-1:0] strobeDly;
  } timing_t;

  function automatic timing_t lookupTiming(input logic [SPEED_W-1:0] code);
    timing_t t;
    case (code)
      3'd0:    begin t.selLen = 4'd7;  t.strobeDly = 4'd2; end
      3'd1:    begin t.selLen = 4'd9;  t.strobeDly = 4'd3; end
      3'd2:    begin t.selLen = 4'd11; t.strobeDly = 4'd4; end
      3'd3:    begin t.selLen = 4'd5;  t.strobeDly = 4'd1; end
      3'd4:    begin t.selLen = 4'd5;  t.strobeDly = 4'd2; end
      3'd5:    begin t.selLen = 4'd5;  t.strobeDly = 4'd3; end
      3'd6:    begin t.selLen = 4'd15; t.strobeDly = 4'd4; end
      default: begin t.selLen = 4'd5;  t.strobeDly = 4'd1; end
    endcase
    return t;
  endfunction
endpackage

// File: rtl/ideTimDatapath.sv
module ideTimDatapath
  import ideTimPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              reqSlow,
  input  ctlStrobes_t       ctl,
  output logic              lastCycle,
  output logic              strobeZone
);
  localparam int CODE_MSB = DATA_W - 1;

  logic [SPEED_W-1:0] speedQ;
  logic [CNT_W-1:0]   selLenQ;
  logic [CNT_W-1:0]   dlyQ;
  logic [CNT_W-1:0]   cnt;
  timing_t            nextTiming;

  always_comb begin
    if (reqSlow) begin
      nextTiming.selLen    = SLOW_SEL;
      nextTiming.strobeDly = SLOW_DLY;
    end else begin
      nextTiming = lookupTiming(speedQ);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      speedQ <= '0;
    end else if (cfgWrite) begin
      speedQ <= cfgData[CODE_MSB -: SPEED_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selLenQ <= '0;
      dlyQ    <= '0;
      cnt     <= '0;
    end else if (ctl.startAcc) begin
      selLenQ <= nextTiming.selLen;
      dlyQ    <= nextTiming.strobeDly;
      cnt     <= '0;
    end else if (ctl.countEn) begin
      cnt <= cnt + 1'b1;
    end else begin
      cnt <= '0;
    end
  end

  assign lastCycle  = (cnt == selLenQ - 1'b1);
  assign strobeZone = (cnt >= dlyQ);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    ctl.countEn |-> (cnt < selLenQ)); // R5
  AST_SLOW_TIMING: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.startAcc && reqSlow) |=> (selLenQ == SLOW_SEL && dlyQ == SLOW_DLY)); // R7
  AST_LATCH_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.countEn && $past(ctl.countEn)) |-> ($stable(selLenQ) && $stable(dlyQ))); // R10
endmodule

// File: rtl/ideTimControl.sv
module ideTimControl
  import ideTimPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        lastCycle,
  input  logic        strobeZone,
  output ctlStrobes_t ctl,
  output logic        selN,
  output logic        iorN,
  output logic        iowN,
  output logic        done
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACTIVE, ST_FIN} state_t;

  state_t stateQ;
  logic   writeQ;
  logic   strobeOn;

  assign ctl.startAcc = (stateQ == ST_IDLE) && reqValid;
  assign ctl.countEn  = (stateQ == ST_ACTIVE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      writeQ <= 1'b0;
    end else begin
      case (stateQ)
        ST_IDLE: if (ctl.startAcc) begin
          stateQ <= ST_ACTIVE;
          writeQ <= reqWrite;
        end
        ST_ACTIVE: if (lastCycle) stateQ <= ST_FIN;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign strobeOn = (stateQ == ST_ACTIVE) && strobeZone;
  assign selN = !(stateQ == ST_ACTIVE);
  assign iorN = !(strobeOn && !writeQ);
  assign iowN = !(strobeOn && writeQ);
  assign done = (stateQ == ST_FIN);

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!iorN && !iowN)); // R6
  AST_STROBE_IN_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    (!iorN || !iowN) |-> !selN); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AFTER_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(selN) |-> done); // R8
  AST_BUSY_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    done |=> selN); // R9
endmodule

// File: rtl/ideStrobeTimer.sv
module ideStrobeTimer
  import ideTimPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSlow,
  input  logic              cfgWrite,
  input  logic [DATA_W-1:0] cfgData,
  output logic              selN,
  output logic              iorN,
  output logic              iowN,
  output logic              done
);
  ctlStrobes_t ctl;
  logic        lastCycle;
  logic        strobeZone;

  ideTimControl u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .lastCycle(lastCycle), .strobeZone(strobeZone), .ctl(ctl),
    .selN(selN), .iorN(iorN), .iowN(iowN), .done(done)
  );

  ideTimDatapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .reqSlow(reqSlow), .ctl(ctl), .lastCycle(lastCycle), .strobeZone(strobeZone)
  );
endmodule

// File: tb/ideStrobeTimer_tb.sv
module ideStrobeTimer_tb;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, reqSlow = 1'b0, cfgWrite = 1'b0;
  logic [7:0] cfgData = 8'h00;
  logic selN, iorN, iowN, done;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ideStrobeTimer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSlow(reqSlow), .cfgWrite(cfgWrite), .cfgData(cfgData),
    .selN(selN), .iorN(iorN), .iowN(iowN), .done(done)
  );

  int expSelTab [8] = '{7, 9, 11, 5, 5, 5, 15, 5};
  int expDlyTab [8] = '{2, 3, 4, 1, 2, 3, 4, 1};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeSpeed(input logic [7:0] val);
    @(negedge clk);
    cfgWrite = 1'b1; cfgData = val;
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic runAccess(input bit wr, input bit slow, input int expSel,
                           input int expDly, input string tag,
                           input bit midCfg, input logic [7:0] midData,
                           input bit midReq);
    int selCnt = 0;
    int firstStrobe = -1;
    int lastSel = -1;
    int doneIdx = -1;
    int doneCnt = 0;
    int badStrobe = 0;
    int outside = 0;
    int restart = 0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSlow = slow;
    @(negedge clk);
    reqValid = 1'b0; reqSlow = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (!selN) begin
        if (doneIdx >= 0) restart++;
        selCnt++;
        lastSel = i;
      end
      if ((wr ? !iowN : !iorN) && firstStrobe < 0) firstStrobe = i;
      if (wr ? !iorN : !iowN) badStrobe++;
      if ((!iorN || !iowN) && selN) outside++;
      if (done) begin
        doneCnt++;
        if (doneIdx < 0) doneIdx = i;
      end
      if (i == 1 && midCfg) begin cfgWrite = 1'b1; cfgData = midData; end
      if ((i == 1 || i == selCnt + 0) && midReq && i < 20) reqValid = 1'b1;
      @(negedge clk);
      cfgWrite = 1'b0;
      reqValid = 1'b0;
    end
    check({tag, " select length"}, selCnt, expSel);
    check({tag, " strobe delay"}, firstStrobe, expDly);
    check("R6 wrong strobe cycles", badStrobe, 0);
    check("R5 strobe outside select / same release", outside, 0);
    check("R8 done position", doneIdx, lastSel + 1);
    check("R8 done width", doneCnt, 1);
    check("R9 no extra access", restart, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R1 selN reset", selN, 1);
    check("R1 iorN reset", iorN, 1);
    check("R1 iowN reset", iowN, 1);
    check("R1 done reset", done, 0);
    runAccess(1'b0, 1'b0, 7, 2, "R1 default code", 1'b0, 8'h00, 1'b0);
  endtask

  task automatic testTable();
    for (int c = 0; c < 8; c++) begin
      writeSpeed({c[2:0], 5'b11111});
      runAccess(c[0], 1'b0, expSelTab[c], expDlyTab[c],
                (c < 3) ? "R3" : "R4", 1'b0, 8'h00, 1'b0);
    end
  endtask

  task automatic testLowBits();
    writeSpeed({3'd6, 5'b00000});
    runAccess(1'b0, 1'b0, 15, 4, "R2 code6 low bits 0", 1'b0, 8'h00, 1'b0);
    writeSpeed({3'd1, 5'b10101});
    runAccess(1'b1, 1'b0, 9, 3, "R2 code1 low bits mixed", 1'b0, 8'h00, 1'b0);
  endtask

  task automatic testSlow();
    writeSpeed({3'd3, 5'b11111});
    runAccess(1'b0, 1'b1, 11, 4, "R7 slow read", 1'b0, 8'h00, 1'b0);
    writeSpeed({3'd6, 5'b11111});
    runAccess(1'b1, 1'b1, 11, 4, "R7 slow write", 1'b0, 8'h00, 1'b0);
    runAccess(1'b1, 1'b0, 15, 4, "R7 table after slow", 1'b0, 8'h00, 1'b0);
  endtask

  task automatic testMidWrite();
    writeSpeed({3'd3, 5'b11111});
    runAccess(1'b0, 1'b0, 5, 1, "R10 current access", 1'b1, {3'd6, 5'b11111}, 1'b0);
    runAccess(1'b0, 1'b0, 15, 4, "R10 next access", 1'b0, 8'h00, 1'b0);
  endtask

  task automatic testBusyReq();
    writeSpeed({3'd0, 5'b11111});
    runAccess(1'b1, 1'b0, 7, 2, "R9 busy request", 1'b0, 8'h00, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTable();
    testLowBits();
    testSlow();
    testMidWrite();
    testBusyReq();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule